// File: doc/BRIEF.md
# Reconfigurable-Width Core Scan Wrapper

This block sits between a core's three internal scan chains (10, 5 and 4 flip-flops by default) and up to three test access wires. A two-bit width code selects how many wires the core uses. At width one, the chains are joined into a single long wrapper chain. At width two, there are two wrapper chains. At width three, each chain runs on its own wire. Multiplexers at the chain inputs choose between a test access input and the tail of the chain before it. Each used output wire carries the tail of its wrapper chain.

A small mode register puts the wrapper in one of three exclusive modes: normal operation, internal (core) test, or external (interconnect) test. A scheduler can stop shifting at any cycle, change the width while shifting is paused, and carry on. The chain contents stay where they were, so a split test never has to reload what it has already shifted. A width code of zero is illegal. It raises an error flag and leaves the old width in force.

Top module: `rwsw_top`

## Requirements
- R1: After reset, `wmode_o` is 3'b001 (normal mode), `tam_o` is 0, `cfg_err_o` is 0, every chain bit is 0 and the width is one.
- R2: Width code 2'b01 (width one) forms one 19-bit chain. `tam_i[0]` feeds the 10-bit chain, whose tail feeds the 5-bit chain, whose tail feeds the 4-bit chain. The tail of the 4-bit chain drives `tam_o[0]`, and `tam_o[2:1]` stay 0.
- R3: Width code 2'b10 (width two) makes two chains. The first is the 10-bit chain, fed from `tam_i[0]` and driving `tam_o[0]`. The second is the 5-bit chain followed by the 4-bit chain, fed from `tam_i[1]` and driving `tam_o[1]`. `tam_o[2]` stays 0.
- R4: Width code 2'b11 (width three) gives each chain its own wire k: the 10-bit, 5-bit and 4-bit chains use k = 0, 1 and 2, taking `tam_i[k]` and driving `tam_o[k]`.
- R5: The select code of the two longer chain multiplexers is 00, 01 or 10 for widths one, two or three. The 4-bit chain select is 0 for widths one and two and 1 for width three.
- R6: The mode code on `mode_i` selects the mode: 00 is normal, 01 is internal test and 10 is external test. The one-hot output `wmode_o` shows the mode: bit 0 is normal, bit 1 internal, bit 2 external. Code 11 leaves the mode unchanged.
- R7: While `shift_en_i` is low and no capture is requested, all chain bits hold. Shifting resumes from the stored position, after a width change as well.
- R8: A width code of 00, sampled while `shift_en_i` is low, sets `cfg_err_o` at the next edge and keeps the previous width. The next legal code clears the flag.
- R9: Width and mode are sampled only on edges where `shift_en_i` is low, and the new value applies from that edge. Codes presented while shifting have no effect.
- R10: Outside internal-test mode `tam_o` is 0. In normal and internal-test modes, `capture_i` with `shift_en_i` low loads `func_i` in parallel: bits [9:0] go to the 10-bit chain, [14:10] to the 5-bit chain and [18:15] to the 4-bit chain, with the highest index at each tail.
- R11: In normal and external-test modes `shift_en_i` does not move the chains. In external-test mode `capture_i` does not load them either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Requested wrapper mode code |
| width_i | input | 2 | Requested wrapper width code |
| shift_en_i | input | 1 | Shift the wrapper chains (internal test only) |
| capture_i | input | 1 | Parallel load of functional data into the chains |
| func_i | input | 19 | Functional data captured into the chains |
| tam_i | input | 3 | Test access input wires |
| tam_o | output | 3 | Test access output wires |
| wmode_o | output | 3 | One-hot current wrapper mode |
| cfg_err_o | output | 1 | Illegal width code seen |

## Verification
Every chain bit is a register, and `tam_o` is decoded from chain tails without a further register. A bit shifted in at edge n can therefore be seen combinationally at a tail after as many edges as the chain segment in front of it is long. The bench drives inputs at the falling edge and compares `tam_o` at the next falling edge, one rising edge later, against a bit-level model of the three chains that it advances by the routing rules. Mode, width and error flag change at the rising edge after a low-shift cycle, so they are checked one half-period after that edge.

// File: rtl/rwsw_pkg.sv
package rwsw_pkg;

    localparam logic [1:0] WID_BAD   = 2'b00;
    localparam logic [1:0] WID_ONE   = 2'b01;
    localparam logic [1:0] WID_TWO   = 2'b10;
    localparam logic [1:0] WID_THREE = 2'b11;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_INTEST = 2'b01;
    localparam logic [1:0] MODE_EXTEST = 2'b10;

    localparam int OH_NORMAL = 0;
    localparam int OH_INTEST = 1;
    localparam int OH_EXTEST = 2;

    typedef struct packed {
        logic [1:0] width;
        logic [2:0] mode_oh;
        logic       err;
    } cfg_t;

    // select for the two longer chain multiplexers
    function automatic logic [1:0] sel_long(input logic [1:0] w);
        case (w)
            WID_ONE: sel_long = 2'b00;
            WID_TWO: sel_long = 2'b01;
            default: sel_long = 2'b10;
        endcase
    endfunction

    // select for the shortest chain multiplexer
    function automatic logic sel_short(input logic [1:0] w);
        sel_short = (w == WID_THREE);
    endfunction

endpackage

// File: rtl/rwsw_cfg.sv
module rwsw_cfg
    import rwsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en_i,
    input  logic [1:0] width_i,
    input  logic [1:0] mode_i,
    output logic [1:0] width_o,
    output logic [2:0] mode_oh_o,
    output logic       err_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!shift_en_i) begin
            cfg_d.err = (width_i == WID_BAD);
            if (width_i != WID_BAD) begin
                cfg_d.width = width_i;
            end
            case (mode_i)
                MODE_NORMAL: cfg_d.mode_oh = 3'b001;
                MODE_INTEST: cfg_d.mode_oh = 3'b010;
                MODE_EXTEST: cfg_d.mode_oh = 3'b100;
                default:     cfg_d.mode_oh = cfg_q.mode_oh;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{width: WID_ONE, mode_oh: 3'b001, err: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign width_o   = cfg_q.width;
    assign mode_oh_o = cfg_q.mode_oh;
    assign err_o     = cfg_q.err;

endmodule

// File: rtl/rwsw_chain.sv
module rwsw_chain #(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_i,
    input  logic           load_i,
    input  logic           scan_in_i,
    input  logic [LEN-1:0] par_i,
    output logic [LEN-1:0] bits_o,
    output logic           tail_o
);

    logic [LEN-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (shift_i) begin
            if (LEN > 1) begin
                bits_d = {bits_q[LEN-2:0], scan_in_i};
            end else begin
                bits_d = scan_in_i;
            end
        end else if (load_i) begin
            bits_d = par_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits_o = bits_q;
    assign tail_o = bits_q[LEN-1];

endmodule

// File: rtl/rwsw_route.sv
module rwsw_route
    import rwsw_pkg::*;
(
    input  logic [1:0] width_i,
    input  logic       intest_i,
    input  logic [2:0] tam_i,
    input  logic [2:0] tail_i,
    output logic [2:0] scan_in_o,
    output logic [2:0] tam_o
);

    logic [1:0] sel_mid;
    logic       sel_last;
    logic [2:0] wires;

    always_comb begin
        sel_mid  = sel_long(width_i);
        sel_last = sel_short(width_i);

        // longest chain: every width maps its input to wire 0
        scan_in_o[0] = tam_i[0];
        scan_in_o[1] = (sel_mid == 2'b00) ? tail_i[0] : tam_i[1];
        scan_in_o[2] = sel_last ? tam_i[2] : tail_i[1];

        case (width_i)
            WID_ONE:   wires = {2'b00, tail_i[2]};
            WID_TWO:   wires = {1'b0, tail_i[2], tail_i[0]};
            WID_THREE: wires = tail_i;
            default:   wires = 3'b000;
        endcase
        tam_o = intest_i ? wires : 3'b000;
    end

endmodule

// File: rtl/rwsw_top.sv
module rwsw_top
    import rwsw_pkg::*;
#(
    parameter int LEN_A = 10,
    parameter int LEN_B = 5,
    parameter int LEN_C = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   mode_i,
    input  logic [1:0]                   width_i,
    input  logic                         shift_en_i,
    input  logic                         capture_i,
    input  logic [LEN_A+LEN_B+LEN_C-1:0] func_i,
    input  logic [2:0]                   tam_i,
    output logic [2:0]                   tam_o,
    output logic [2:0]                   wmode_o,
    output logic                         cfg_err_o
);

    localparam int TOTAL = LEN_A + LEN_B + LEN_C;
    localparam int N_CH  = 3;

    function automatic int ch_len(input int k);
        ch_len = (k == 0) ? LEN_A : (k == 1) ? LEN_B : LEN_C;
    endfunction

    function automatic int ch_off(input int k);
        ch_off = (k == 0) ? 0 : (k == 1) ? LEN_A : LEN_A + LEN_B;
    endfunction

    logic [1:0]       cur_width;
    logic [2:0]       mode_oh;
    logic             do_shift;
    logic             do_load;
    logic [N_CH-1:0]  scan_in;
    logic [N_CH-1:0]  tails;
    logic [TOTAL-1:0] chain_q;

    rwsw_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en_i),
        .width_i    (width_i),
        .mode_i     (mode_i),
        .width_o    (cur_width),
        .mode_oh_o  (mode_oh),
        .err_o      (cfg_err_o)
    );

    assign do_shift = shift_en_i & mode_oh[OH_INTEST];
    assign do_load  = ~shift_en_i & capture_i
                    & (mode_oh[OH_NORMAL] | mode_oh[OH_INTEST]);

    for (genvar k = 0; k < N_CH; k++) begin : g_chain
        localparam int L = ch_len(k);
        localparam int O = ch_off(k);
        rwsw_chain #(.LEN(L)) u_chain (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_i   (do_shift),
            .load_i    (do_load),
            .scan_in_i (scan_in[k]),
            .par_i     (func_i[O +: L]),
            .bits_o    (chain_q[O +: L]),
            .tail_o    (tails[k])
        );
    end

    rwsw_route u_route (
        .width_i   (cur_width),
        .intest_i  (mode_oh[OH_INTEST]),
        .tam_i     (tam_i),
        .tail_i    (tails),
        .scan_in_o (scan_in),
        .tam_o     (tam_o)
    );

    assign wmode_o = mode_oh;

endmodule

// File: rtl/rwsw_checker.sv
module rwsw_checker #(
    parameter int LEN_A = 10,
    parameter int TOTAL = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_en_i,
    input logic             capture_i,
    input logic [1:0]       width_i,
    input logic [2:0]       tam_i,
    input logic [2:0]       tam_o,
    input logic [2:0]       wmode_o,
    input logic             cfg_err_o,
    input logic [1:0]       cur_width,
    input logic [TOTAL-1:0] chain_q
);

    p_mode_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wmode_o) == 1);

    p_quiet_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wmode_o[1] |-> tam_o == 3'b000);

    p_flag_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en_i && width_i == 2'b00) |=> cfg_err_o);

    p_keep_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en_i && width_i == 2'b00) |=> cur_width == $past(cur_width));

    p_frozen_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> ($stable(wmode_o) && $stable(cur_width)));

    p_hold_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en_i && !capture_i) |=> $stable(chain_q));

    p_ext_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wmode_o[2] |=> $stable(chain_q));

    p_join_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wmode_o[1] && shift_en_i && cur_width == 2'b01)
        |=> chain_q[LEN_A] == $past(chain_q[LEN_A-1]));

    p_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wmode_o[1] && shift_en_i && cur_width == 2'b10)
        |=> chain_q[LEN_A] == $past(tam_i[1]));

    p_wire0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wmode_o[1] && shift_en_i) |=> chain_q[0] == $past(tam_i[0]));

    p_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_width == 2'b01) |-> tam_o[2:1] == 2'b00);

endmodule

bind rwsw_top rwsw_checker #(.LEN_A(LEN_A), .TOTAL(TOTAL)) u_rwsw_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (shift_en_i),
    .capture_i  (capture_i),
    .width_i    (width_i),
    .tam_i      (tam_i),
    .tam_o      (tam_o),
    .wmode_o    (wmode_o),
    .cfg_err_o  (cfg_err_o),
    .cur_width  (cur_width),
    .chain_q    (chain_q)
);

// File: tb/rwsw_top_tb.sv
module rwsw_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [1:0]  width_i = 2'b01;
    logic        shift_en_i = 1'b0;
    logic        capture_i = 1'b0;
    logic [18:0] func_i = '0;
    logic [2:0]  tam_i = '0;
    logic [2:0]  tam_o;
    logic [2:0]  wmode_o;
    logic        cfg_err_o;

    always #10 clk = ~clk;

    rwsw_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .width_i    (width_i),
        .shift_en_i (shift_en_i),
        .capture_i  (capture_i),
        .func_i     (func_i),
        .tam_i      (tam_i),
        .tam_o      (tam_o),
        .wmode_o    (wmode_o),
        .cfg_err_o  (cfg_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state: bits [9:0] long, [14:10] mid, [18:15] short chain
    logic [18:0] mq = '0;
    logic [1:0]  mw = 2'b01;
    logic [2:0]  mm = 3'b001;
    logic        me = 1'b0;

    typedef struct packed {
        logic [1:0]  w;
        logic [18:0] f;
        logic [4:0]  n;
        logic [2:0]  tin;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, 19'h5A3C7, 5'd19, 3'b101},
        '{2'b10, 19'h2F0F1, 5'd10, 3'b011},
        '{2'b11, 19'h70E1B, 5'd10, 3'b110},
        '{2'b01, 19'h00001, 5'd6,  3'b111},
        '{2'b11, 19'h7FFFF, 5'd4,  3'b000},
        '{2'b10, 19'h12345, 5'd12, 3'b010}
    };

    function automatic logic [2:0] exp_out();
        if (!mm[1]) return 3'b000;
        case (mw)
            2'b01:   return {2'b00, mq[18]};
            2'b10:   return {1'b0, mq[18], mq[9]};
            default: return {mq[18], mq[14], mq[9]};
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check({29'd0, tam_o}, {29'd0, exp_out()}, req);
    endtask

    task automatic low_cycle_model();
        me = (width_i == 2'b00);
        if (width_i != 2'b00) mw = width_i;
        case (mode_i)
            2'b00: mm = 3'b001;
            2'b01: mm = 3'b010;
            2'b10: mm = 3'b100;
            default: ;
        endcase
    endtask

    task automatic set_cfg(input logic [1:0] w, input logic [1:0] m);
        shift_en_i = 1'b0;
        capture_i  = 1'b0;
        width_i    = w;
        mode_i     = m;
        tick();
        low_cycle_model();
    endtask

    task automatic cap(input logic [18:0] f);
        func_i    = f;
        capture_i = 1'b1;
        tick();
        capture_i = 1'b0;
        if (mm[0] || mm[1]) mq = f;
        low_cycle_model();
    endtask

    task automatic shift1(input logic [2:0] tin);
        logic ib, ic;
        tam_i      = tin;
        shift_en_i = 1'b1;
        tick();
        shift_en_i = 1'b0;
        if (mm[1]) begin
            ib = (mw == 2'b01) ? mq[9] : tin[1];
            ic = (mw == 2'b11) ? tin[2] : mq[14];
            mq = {mq[17:15], ic, mq[13:10], ib, mq[8:0], tin[0]};
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({29'd0, wmode_o}, 32'd1, "R1 mode");
        check({29'd0, tam_o}, 32'd0, "R1 tam_o");
        check({31'd0, cfg_err_o}, 32'd0, "R1 err");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: chain bits reset to zero and width one
        set_cfg(2'b01, 2'b01);
        for (int k = 0; k < 19; k++) begin
            check_out("R1 cleared chain");
            shift1(3'b000);
        end

        // vector table: R2, R3, R4, R5 and R10 capture packing
        foreach (VECS[v]) begin
            tag = (VECS[v].w == 2'b01) ? "R2/R5 width one" :
                  (VECS[v].w == 2'b10) ? "R3/R5 width two" : "R4/R5 width three";
            set_cfg(VECS[v].w, 2'b01);
            cap(VECS[v].f);
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                check_out(tag);
                shift1(VECS[v].tin ^ 3'(k));
            end
            check_out(tag);
        end

        // R6: mode codes and the ignored code
        set_cfg(2'b11, 2'b10);
        check({29'd0, wmode_o}, 32'd4, "R6 extest");
        set_cfg(2'b11, 2'b11);
        check({29'd0, wmode_o}, 32'd4, "R6 code 11 ignored");
        set_cfg(2'b11, 2'b00);
        check({29'd0, wmode_o}, 32'd1, "R6 normal");

        // R8: illegal width flagged and old width kept
        set_cfg(2'b10, 2'b01);
        cap(19'h3C5A6);
        set_cfg(2'b00, 2'b01);
        check({31'd0, cfg_err_o}, 32'd1, "R8 flag set");
        width_i = 2'b00;
        for (int k = 0; k < 3; k++) begin
            check_out("R8 width kept");
            shift1(3'b011);
        end
        set_cfg(2'b10, 2'b01);
        check({31'd0, cfg_err_o}, 32'd0, "R8 flag cleared");

        // R9: width and mode requests during shifting are ignored
        set_cfg(2'b11, 2'b01);
        cap(19'h4D2B3);
        width_i = 2'b01;
        mode_i  = 2'b00;
        shift1(3'b101);
        width_i = 2'b11;
        mode_i  = 2'b01;
        check({29'd0, wmode_o}, 32'd2, "R9 mode frozen");
        check_out("R9 width frozen");
        shift1(3'b010);
        check_out("R9 width frozen after");

        // R7: pause holds, resume after width change continues
        set_cfg(2'b11, 2'b01);
        cap(19'h6B1E9);
        for (int k = 0; k < 3; k++) shift1(3'(k + 1));
        for (int k = 0; k < 4; k++) begin
            tick();
            check_out("R7 pause hold");
        end
        set_cfg(2'b01, 2'b01);
        for (int k = 0; k < 19; k++) begin
            check_out("R7 resume width one");
            shift1(3'b001 ^ 3'(k));
        end

        // R10: normal mode quiet output, capture works, shift ignored
        set_cfg(2'b11, 2'b00);
        cap(19'h1F3C4);
        check({29'd0, tam_o}, 32'd0, "R10 normal quiet");
        shift1(3'b111);
        shift1(3'b111);
        set_cfg(2'b11, 2'b01);
        check_out("R10 capture in normal, shift ignored");

        // R11: external mode ignores capture and shift
        set_cfg(2'b11, 2'b10);
        cap(19'h00000);
        shift1(3'b111);
        check({29'd0, tam_o}, 32'd0, "R11 ext quiet");
        set_cfg(2'b11, 2'b01);
        check_out("R11 ext chains held");
        check({29'd0, tam_o}, {29'd0, 1'b0, 1'b1, 1'b1}, "R11 held bits");

        finish_run();
    end

endmodule